// File: doc/BRIEF.md
# Home Directory Coherence Controller

This block is the home-side directory engine for a group of memory blocks kept coherent by a linked-list sharing scheme. For each block it holds one stable state and one node pointer. In the shared state the pointer names the head of the sharer list. In the exclusive state it names the single remote owner. Remote nodes send read, ownership and write-miss requests. The controller serializes these requests per block. It replies from home memory, forwards the request to the current owner, or starts an invalidation chain down the sharer list.

An invalidation chain leaves the block in a waiting state until one acknowledgement comes back from the list tail. That acknowledgement carries the ID of the node that ended up owning the block. While a block is waiting, new requests to that block are held off with back-pressure, and requests to other blocks are still served. Every accepted request or acknowledgement produces at most one outgoing message, registered one cycle later. The network, data storage and processor caches are outside this block.

Top module: `home_dir_ctrl`

## Requirements
- R1: After reset every block is Resident with a null (0) pointer, `msg_valid_o` is low and `req_ready_o` is high.
- R2: A read (op 0) to a Resident block emits, one cycle after acceptance, a shared-data reply (code 1) to the requester with id 0. The block becomes shared with the requester as list head.
- R3: A read to a shared block emits a shared-data reply (code 1) to the requester whose id field is the previous head. The requester becomes the new head.
- R4: A read to an exclusively owned block emits a shared forward (code 3) to the owner with id = requester. The block becomes shared with the requester as head.
- R5: An ownership request (op 1) or write miss (op 2) to a Resident block emits an exclusive-data reply (code 2) to the requester with id 0. The requester becomes owner.
- R6: An ownership request or write miss to an owned block emits an exclusive forward (code 4) to the old owner with id = requester. The requester becomes owner.
- R7: An ownership request to a shared block emits a selective invalidation (code 6) to the list head with the null id 0, and the block enters a waiting state.
- R8: A write miss to a shared block emits a plain invalidation (code 5) to the list head with id = requester, and the block enters a waiting state.
- R9: While a block waits, `req_ready_o` is low for requests to that block. Requests to other blocks are accepted and answered normally.
- R10: An acknowledgement with a nonzero id for a waiting block makes that id the owner. After a plain chain it also emits an exclusive-data reply (code 2, id 0) to that id. After a selective chain it emits nothing.
- R11: An acknowledgement with id 0 for a waiting block returns the block to Resident and emits nothing.
- R12: An acknowledgement for a block that is not waiting has no effect on state or output.
- R13: In any cycle with `ack_valid_i` high, `req_ready_o` is low.
- R14: Every outgoing message carries the index of the block it concerns in `msg_blk_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request accepted this cycle when valid |
| req_op_i | input | 2 | 0 read, 1 ownership, 2 write miss (3 treated as read) |
| req_blk_i | input | BLK_W | Block index of the request |
| req_src_i | input | NODE_W | Requesting node ID (nonzero) |
| ack_valid_i | input | 1 | Chain-completion acknowledgement present |
| ack_blk_i | input | BLK_W | Block index the acknowledgement concerns |
| ack_id_i | input | NODE_W | Node that claimed ownership, 0 if none |
| msg_valid_o | output | 1 | Outgoing message valid for one cycle |
| msg_op_o | output | 3 | Message code (1 to 6) |
| msg_dst_o | output | NODE_W | Destination node |
| msg_blk_o | output | BLK_W | Block index |
| msg_id_o | output | NODE_W | Link, requester, claimant or null ID |

## Verification
The bench builds a three-node sharer list and checks that each reply carries the previous head as its link. A design that failed to replace the head would link a requester to itself or to a stale node. It then opens a selective chain and confirms that the busy block stalls while a different block is still served. A design that blocked globally, or let the request through, would fail here. Acknowledgements are driven to an idle block, with a null ID, and in the same cycle as a request, to catch designs that corrupt idle entries, leave null-claim blocks owned, or accept a request that would collide with the acknowledgement's message. Forwarding after a plain chain checks that the acknowledged ID, not the old head, becomes owner.

// File: rtl/home_dir_pkg.sv
package home_dir_pkg;

  typedef enum logic [2:0] {
    ST_RES      = 3'd0,
    ST_SHR      = 3'd1,
    ST_EXR      = 3'd2,
    ST_WAIT_SEL = 3'd3,
    ST_WAIT_INV = 3'd4
  } dir_state_e;

  typedef enum logic [1:0] {
    OP_RD  = 2'd0,
    OP_OWN = 2'd1,
    OP_WRM = 2'd2
  } req_op_e;

  typedef enum logic [2:0] {
    M_NONE    = 3'd0,
    M_DATA_SH = 3'd1,
    M_DATA_EX = 3'd2,
    M_FWD_SH  = 3'd3,
    M_FWD_EX  = 3'd4,
    M_INV     = 3'd5,
    M_INV_SEL = 3'd6
  } msg_op_e;

  function automatic logic is_wait(dir_state_e s);
    return (s == ST_WAIT_SEL) || (s == ST_WAIT_INV);
  endfunction

endpackage

// File: rtl/dir_table.sv
module dir_table
  import home_dir_pkg::*;
#(
  parameter int NUM_BLK = 8,
  parameter int NODE_W  = 3,
  localparam int BLK_W  = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BLK_W-1:0]  rq_blk_i,
  output dir_state_e        rq_state_o,
  output logic [NODE_W-1:0] rq_ptr_o,
  input  logic [BLK_W-1:0]  ak_blk_i,
  output dir_state_e        ak_state_o,
  input  logic              wr_en_i,
  input  logic [BLK_W-1:0]  wr_blk_i,
  input  dir_state_e        wr_state_i,
  input  logic [NODE_W-1:0] wr_ptr_i
);

  dir_state_e        st_q  [NUM_BLK];
  logic [NODE_W-1:0] ptr_q [NUM_BLK];

  for (genvar g = 0; g < NUM_BLK; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        st_q[g]  <= ST_RES;
        ptr_q[g] <= '0;
      end else if (wr_en_i && (wr_blk_i == BLK_W'(g))) begin
        st_q[g]  <= wr_state_i;
        ptr_q[g] <= wr_ptr_i;
      end
    end
  end

  assign rq_state_o = st_q[rq_blk_i];
  assign rq_ptr_o   = ptr_q[rq_blk_i];
  assign ak_state_o = st_q[ak_blk_i];

  // R10
  owner_nonnull_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_state_i == ST_EXR) |-> (wr_ptr_i != '0));

endmodule

// File: rtl/dir_xition.sv
module dir_xition
  import home_dir_pkg::*;
#(
  parameter int NODE_W = 3
) (
  input  logic              req_fire_i,
  input  req_op_e           req_op_i,
  input  logic [NODE_W-1:0] req_src_i,
  input  dir_state_e        req_state_i,
  input  logic [NODE_W-1:0] req_ptr_i,
  input  logic              ack_hit_i,
  input  logic [NODE_W-1:0] ack_id_i,
  input  dir_state_e        ack_state_i,
  output logic              wr_en_o,
  output dir_state_e        wr_state_o,
  output logic [NODE_W-1:0] wr_ptr_o,
  output logic              msg_en_o,
  output msg_op_e           msg_op_o,
  output logic [NODE_W-1:0] msg_dst_o,
  output logic [NODE_W-1:0] msg_id_o
);

  always_comb begin
    wr_en_o    = 1'b0;
    wr_state_o = ST_RES;
    wr_ptr_o   = '0;
    msg_en_o   = 1'b0;
    msg_op_o   = M_NONE;
    msg_dst_o  = '0;
    msg_id_o   = '0;
    if (ack_hit_i) begin
      wr_en_o = 1'b1;
      if (ack_id_i != '0) begin
        wr_state_o = ST_EXR;
        wr_ptr_o   = ack_id_i;
        if (ack_state_i == ST_WAIT_INV) begin
          msg_en_o  = 1'b1;
          msg_op_o  = M_DATA_EX;
          msg_dst_o = ack_id_i;
        end
      end
    end else if (req_fire_i) begin
      wr_en_o  = 1'b1;
      msg_en_o = 1'b1;
      wr_ptr_o = req_src_i;
      if (req_op_i == OP_OWN || req_op_i == OP_WRM) begin
        wr_state_o = ST_EXR;
        unique case (req_state_i)
          ST_SHR: begin
            wr_ptr_o  = req_ptr_i;
            msg_dst_o = req_ptr_i;
            if (req_op_i == OP_OWN) begin
              wr_state_o = ST_WAIT_SEL;
              msg_op_o   = M_INV_SEL;
            end else begin
              wr_state_o = ST_WAIT_INV;
              msg_op_o   = M_INV;
              msg_id_o   = req_src_i;
            end
          end
          ST_EXR: begin
            msg_op_o  = M_FWD_EX;
            msg_dst_o = req_ptr_i;
            msg_id_o  = req_src_i;
          end
          default: begin
            msg_op_o  = M_DATA_EX;
            msg_dst_o = req_src_i;
          end
        endcase
      end else begin
        wr_state_o = ST_SHR;
        unique case (req_state_i)
          ST_SHR: begin
            msg_op_o  = M_DATA_SH;
            msg_dst_o = req_src_i;
            msg_id_o  = req_ptr_i;
          end
          ST_EXR: begin
            msg_op_o  = M_FWD_SH;
            msg_dst_o = req_ptr_i;
            msg_id_o  = req_src_i;
          end
          default: begin
            msg_op_o  = M_DATA_SH;
            msg_dst_o = req_src_i;
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/dir_msg_reg.sv
module dir_msg_reg
  import home_dir_pkg::*;
#(
  parameter int NODE_W = 3,
  parameter int BLK_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              msg_en_i,
  input  msg_op_e           msg_op_i,
  input  logic [NODE_W-1:0] msg_dst_i,
  input  logic [BLK_W-1:0]  msg_blk_i,
  input  logic [NODE_W-1:0] msg_id_i,
  output logic              msg_valid_o,
  output logic [2:0]        msg_op_o,
  output logic [NODE_W-1:0] msg_dst_o,
  output logic [BLK_W-1:0]  msg_blk_o,
  output logic [NODE_W-1:0] msg_id_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      msg_valid_o <= 1'b0;
      msg_op_o    <= '0;
      msg_dst_o   <= '0;
      msg_blk_o   <= '0;
      msg_id_o    <= '0;
    end else begin
      msg_valid_o <= msg_en_i;
      if (msg_en_i) begin
        msg_op_o  <= msg_op_i;
        msg_dst_o <= msg_dst_i;
        msg_blk_o <= msg_blk_i;
        msg_id_o  <= msg_id_i;
      end
    end
  end

  // R14
  msg_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_en_i |=> (msg_valid_o && msg_blk_o == $past(msg_blk_i)));

endmodule

// File: rtl/home_dir_ctrl.sv
module home_dir_ctrl
  import home_dir_pkg::*;
#(
  parameter int NUM_BLK = 8,
  parameter int NODE_W  = 3,
  localparam int BLK_W  = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [1:0]        req_op_i,
  input  logic [BLK_W-1:0]  req_blk_i,
  input  logic [NODE_W-1:0] req_src_i,
  input  logic              ack_valid_i,
  input  logic [BLK_W-1:0]  ack_blk_i,
  input  logic [NODE_W-1:0] ack_id_i,
  output logic              msg_valid_o,
  output logic [2:0]        msg_op_o,
  output logic [NODE_W-1:0] msg_dst_o,
  output logic [BLK_W-1:0]  msg_blk_o,
  output logic [NODE_W-1:0] msg_id_o
);

  dir_state_e        rq_state, ak_state, wr_state;
  logic [NODE_W-1:0] rq_ptr, wr_ptr, nx_dst, nx_id;
  logic              wr_en, nx_en, ack_hit, req_fire;
  msg_op_e           nx_op;
  req_op_e           op_dec;
  logic [BLK_W-1:0]  wr_blk;

  always_comb begin
    unique case (req_op_i)
      2'd1:    op_dec = OP_OWN;
      2'd2:    op_dec = OP_WRM;
      default: op_dec = OP_RD;
    endcase
  end

  // ack owns the cycle; a waiting block back-pressures its own requests
  assign ack_hit     = ack_valid_i && is_wait(ak_state);
  assign req_ready_o = !ack_valid_i && !is_wait(rq_state);
  assign req_fire    = req_valid_i && req_ready_o;
  assign wr_blk      = ack_hit ? ack_blk_i : req_blk_i;

  dir_table #(.NUM_BLK(NUM_BLK), .NODE_W(NODE_W)) u_table (
    .clk_i, .rst_ni,
    .rq_blk_i(req_blk_i), .rq_state_o(rq_state), .rq_ptr_o(rq_ptr),
    .ak_blk_i(ack_blk_i), .ak_state_o(ak_state),
    .wr_en_i(wr_en), .wr_blk_i(wr_blk), .wr_state_i(wr_state), .wr_ptr_i(wr_ptr)
  );

  dir_xition #(.NODE_W(NODE_W)) u_xition (
    .req_fire_i(req_fire), .req_op_i(op_dec), .req_src_i(req_src_i),
    .req_state_i(rq_state), .req_ptr_i(rq_ptr),
    .ack_hit_i(ack_hit), .ack_id_i(ack_id_i), .ack_state_i(ak_state),
    .wr_en_o(wr_en), .wr_state_o(wr_state), .wr_ptr_o(wr_ptr),
    .msg_en_o(nx_en), .msg_op_o(nx_op), .msg_dst_o(nx_dst), .msg_id_o(nx_id)
  );

  dir_msg_reg #(.NODE_W(NODE_W), .BLK_W(BLK_W)) u_msg (
    .clk_i, .rst_ni,
    .msg_en_i(nx_en), .msg_op_i(nx_op), .msg_dst_i(nx_dst),
    .msg_blk_i(wr_blk), .msg_id_i(nx_id),
    .msg_valid_o, .msg_op_o, .msg_dst_o, .msg_blk_o, .msg_id_o
  );

  // R7
  inv_sel_null_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_valid_o && msg_op_o == 3'(M_INV_SEL)) |-> (msg_id_o == '0));

  // R13
  ack_prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_valid_i |-> !(req_valid_i && req_ready_o));

  // R9
  stall_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_ready_o && !ack_valid_i) |=> !msg_valid_o);

  // R2
  fire_msg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_fire |=> msg_valid_o);

endmodule

// File: tb/tb_home_dir_ctrl.sv
module tb_home_dir_ctrl;
  localparam int NB = 8;
  localparam int NW = 3;
  localparam int BW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [1:0] req_op = '0;
  logic [BW-1:0] req_blk = '0;
  logic [NW-1:0] req_src = '0;
  logic ack_valid = 1'b0;
  logic [BW-1:0] ack_blk = '0;
  logic [NW-1:0] ack_id = '0;
  logic msg_valid;
  logic [2:0] msg_op;
  logic [NW-1:0] msg_dst, msg_id;
  logic [BW-1:0] msg_blk;

  int total = 0;
  int bad = 0;

  typedef struct packed {
    logic [2:0] op;
    logic [NW-1:0] dst;
    logic [BW-1:0] blk;
    logic [NW-1:0] id;
    logic [7:0] rq;
  } exp_t;
  exp_t expq[$];

  always #10 clk = ~clk;

  home_dir_ctrl #(.NUM_BLK(NB), .NODE_W(NW)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_op_i(req_op),
    .req_blk_i(req_blk), .req_src_i(req_src),
    .ack_valid_i(ack_valid), .ack_blk_i(ack_blk), .ack_id_i(ack_id),
    .msg_valid_o(msg_valid), .msg_op_o(msg_op), .msg_dst_o(msg_dst),
    .msg_blk_o(msg_blk), .msg_id_o(msg_id)
  );

  // monitor
  always @(posedge clk) begin
    #1;
    if (rst_n && msg_valid) begin
      total++;
      if (expq.size() == 0) begin
        bad++;
        $display("FAIL unexpected message R12: got op=%0d dst=%0d blk=%0d id=%0d exp none",
                 msg_op, msg_dst, msg_blk, msg_id);
      end else begin
        exp_t e;
        e = expq.pop_front();
        if (msg_op != e.op || msg_dst != e.dst || msg_blk != e.blk || msg_id != e.id) begin
          bad++;
          $display("FAIL R%0d: got op=%0d dst=%0d blk=%0d id=%0d exp op=%0d dst=%0d blk=%0d id=%0d",
                   e.rq, msg_op, msg_dst, msg_blk, msg_id, e.op, e.dst, e.blk, e.id);
        end
      end
    end
  end

  task automatic check(input bit ok, input string what, input int act, input int exp_v);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: act=%0d exp=%0d", what, act, exp_v);
    end
  endtask

  task automatic send_req(input int op, input int blk, input int src,
                          input int eop, input int edst, input int eid, input int rq);
    exp_t e;
    @(negedge clk);
    req_op = 2'(op); req_blk = BW'(blk); req_src = NW'(src); req_valid = 1'b1;
    #1;
    check(req_ready == 1'b1, $sformatf("R9 ready for R%0d request", rq), int'(req_ready), 1);
    @(posedge clk);
    e.op = 3'(eop); e.dst = NW'(edst); e.blk = BW'(blk); e.id = NW'(eid); e.rq = 8'(rq);
    expq.push_back(e);
    #1 req_valid = 1'b0;
  endtask

  task automatic send_ack(input int blk, input int id, input bit has_msg, input int edst, input int rq);
    exp_t e;
    @(negedge clk);
    ack_blk = BW'(blk); ack_id = NW'(id); ack_valid = 1'b1;
    @(posedge clk);
    if (has_msg) begin
      e.op = 3'd2; e.dst = NW'(edst); e.blk = BW'(blk); e.id = '0; e.rq = 8'(rq);
      expq.push_back(e);
    end
    #1 ack_valid = 1'b0;
  endtask

  task automatic try_blocked(input int op, input int blk, input int src, input string what);
    @(negedge clk);
    req_op = 2'(op); req_blk = BW'(blk); req_src = NW'(src); req_valid = 1'b1;
    #1;
    check(req_ready == 1'b0, what, int'(req_ready), 0);
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1
    check(msg_valid == 1'b0, "R1 msg_valid in reset", int'(msg_valid), 0);
    @(negedge clk) rst_n = 1'b1;
    #1;
    check(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
    check(msg_valid == 1'b0, "R1 msg_valid after reset", int'(msg_valid), 0);

    // build list on block 0: R2, R3
    send_req(0, 0, 1, 1, 1, 0, 2);
    send_req(0, 0, 2, 1, 2, 1, 3);
    send_req(0, 0, 3, 1, 3, 2, 3);
    // R7 selective invalidation to head 3
    send_req(1, 0, 2, 6, 3, 0, 7);
    // R9 busy block stalls, other block served
    try_blocked(0, 0, 4, "R9 busy block stalls");
    send_req(0, 1, 5, 1, 5, 0, 9);
    // R12 ack to idle block 2 ignored; block 2 still Resident
    send_ack(2, 6, 1'b0, 0, 12);
    send_req(0, 2, 1, 1, 1, 0, 12);
    // R10 selective completion: owner 2, no message
    send_ack(0, 2, 1'b0, 0, 10);
    // R4 read to owned block forwards to owner 2
    send_req(0, 0, 4, 3, 2, 4, 4);
    // R8 write miss on shared block (head 4)
    send_req(2, 0, 5, 5, 4, 5, 8);
    try_blocked(2, 0, 6, "R9 busy after plain invalidation");
    // R10 plain completion: data to claimant 5
    send_ack(0, 5, 1'b1, 5, 10);
    // R6 ownership and write miss on owned block
    send_req(1, 0, 6, 4, 5, 6, 6);
    send_req(2, 0, 7, 4, 6, 7, 6);
    // R5 on Resident blocks
    send_req(1, 3, 1, 2, 1, 0, 5);
    send_req(2, 4, 2, 2, 2, 0, 5);
    // R11 and R13 on block 5
    send_req(0, 5, 1, 1, 1, 0, 2);
    send_req(0, 5, 2, 1, 2, 1, 3);
    send_req(1, 5, 3, 6, 2, 0, 7);
    @(negedge clk);
    ack_blk = 3'd5; ack_id = '0; ack_valid = 1'b1;
    req_op = 2'd0; req_blk = 3'd6; req_src = 3'd4; req_valid = 1'b1;
    #1;
    check(req_ready == 1'b0, "R13 ready low during ack", int'(req_ready), 0);
    @(posedge clk);
    #1 begin ack_valid = 1'b0; req_valid = 1'b0; end
    send_req(0, 5, 7, 1, 7, 0, 11);
    send_req(0, 6, 4, 1, 4, 0, 13);

    repeat (4) @(posedge clk);
    #2;
    check(expq.size() == 0, "R14 all expected messages seen", expq.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule